// File: doc/BRIEF.md
# Coded Clock Divider

The block derives a slower clock from a fast source clock. A 4-bit ratio code, normally held in a configuration register, is split into two fields: the low field picks a base ratio and the high field scales it by a power of two. A build-time parameter chooses between two base-ratio tables. One table serves processor and hub clocks. The other serves peripheral-bus clocks. Several of the resulting ratios are odd.

A per-output invert bit flips the phase of the divided clock. An enable bit gates the output, and a disabled output rests at logic low. The ratio code, the invert bit and the enable bit are sampled only at the last source cycle of each output period. A new setting therefore starts on a fresh period, and no runt or partial pulse can appear.

At reset the code presented on the inputs sets the first ratio, so the power-up setting comes from whatever strap-derived value the surrounding logic supplies.

Top module: `coded_clk_divider`

## Requirements
- R1: With TABLE_SEL = 0, code bits [1:0] select base ratio 2, 3, 5 or 7 for values 0, 1, 2 and 3.
- R2: Code bits [3:2] with value k multiply the base ratio by 2^k (x1, x2, x4, x8). The full range is /2 to /56 for TABLE_SEL = 0 and /3 to /72 for TABLE_SEL = 1.
- R3: With TABLE_SEL = 1, code bits [1:0] select base ratio 4, 3, 5 or 9 for values 0, 1, 2 and 3.
- R4: For ratio N, an enabled and non-inverted output is high for floor(N/2) source cycles and then low for the remaining cycles. Each period starts with its high phase. For odd N, the duty cycle is half a source period short of 50%.
- R5: When the invert bit is 1, the enabled output is the complement of the R4 waveform over the whole period.
- R6: When the enable bit is 0, the output is held at logic low for the whole period.
- R7: The code, invert and enable inputs are sampled only at the last source cycle of a period. Changes at any other time have no effect on the current period.
- R8: While reset is asserted, the output is low. The code present at reset release sets the first period, which starts at the first clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| div_code | input | 4 | Ratio code: bits [1:0] base select, bits [3:2] power-of-two scale |
| inv_en | input | 1 | 1 inverts the divided clock |
| out_en | input | 1 | 1 enables the output; 0 holds it low |
| clk_out | output | 1 | Divided clock, registered |

## Verification
Every base-ratio code of both tables is applied unscaled. This separates the tables and shows that odd ratios get the floor-half high phase. Scaled codes up to the largest multiplier check that the two fields combine as a product and not as a sum, and that the counter width holds the longest period. Inverted and disabled periods distinguish the phase flip from plain gating. During every period the bench drives the complement of each input, so any sampling outside the period boundary shows up as a wrong waveform.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned MAX_RATIO = 72;
  localparam int unsigned CNT_W     = $clog2(MAX_RATIO + 1);

  typedef logic [CNT_W-1:0]  ratio_t;
  typedef logic [CODE_W-1:0] code_t;

  // base ratio picked by the low code field; pci selects the second table
  function automatic ratio_t base_of(input logic pci, input logic [1:0] sel);
    ratio_t b;
    unique case (sel)
      2'd0:    b = pci ? ratio_t'(4) : ratio_t'(2);
      2'd1:    b = ratio_t'(3);
      2'd2:    b = ratio_t'(5);
      default: b = pci ? ratio_t'(9) : ratio_t'(7);
    endcase
    return b;
  endfunction

  // full ratio: base scaled by a power of two from the high field
  function automatic ratio_t ratio_of(input logic pci, input code_t code);
    return base_of(pci, code[1:0]) << code[3:2];
  endfunction

  // source cycles spent high in one period
  function automatic ratio_t high_of(input ratio_t r);
    return r >> 1;
  endfunction
endpackage

// File: rtl/cdiv_ratio_decode.sv
module cdiv_ratio_decode
  import cdiv_pkg::*;
#(
  parameter bit TABLE_SEL = 1'b0
) (
  input  code_t  code,
  output ratio_t ratio,
  output ratio_t high_len
);
  generate
    if (TABLE_SEL) begin : g_pci_table
      assign ratio = ratio_of(1'b1, code);
    end else begin : g_cpu_table
      assign ratio = ratio_of(1'b0, code);
    end
  endgenerate

  assign high_len = high_of(ratio);
endmodule

// File: rtl/cdiv_period_ctr.sv
module cdiv_period_ctr
  import cdiv_pkg::*;
#(
  parameter bit TABLE_SEL = 1'b0
) (
  input  logic   clk_src,
  input  logic   rst_n,
  input  ratio_t ratio_in,
  input  ratio_t high_in,
  input  logic   en_in,
  input  logic   inv_in,
  output ratio_t cnt_nx,
  output ratio_t high_nx,
  output logic   en_nx,
  output logic   inv_nx,
  output ratio_t cnt_q,
  output logic   en_q,
  output logic   inv_q,
  output logic   at_end
);
  localparam ratio_t MIN_RATIO = TABLE_SEL ? ratio_t'(3) : ratio_t'(2);

  ratio_t ratio_q;
  ratio_t high_q;

  assign at_end = (cnt_q == ratio_q - 1'b1);

  always_comb begin
    if (at_end) begin
      cnt_nx  = '0;
      high_nx = high_in;
      en_nx   = en_in;
      inv_nx  = inv_in;
    end else begin
      cnt_nx  = cnt_q + 1'b1;
      high_nx = high_q;
      en_nx   = en_q;
      inv_nx  = inv_q;
    end
  end

  always_ff @(posedge clk_src) begin
    if (!rst_n) begin
      cnt_q   <= ratio_in - 1'b1;
      ratio_q <= ratio_in;
      high_q  <= high_in;
      en_q    <= en_in;
      inv_q   <= inv_in;
    end else begin
      cnt_q <= cnt_nx;
      if (at_end) begin
        ratio_q <= ratio_in;
        high_q  <= high_nx;
        en_q    <= en_nx;
        inv_q   <= inv_nx;
      end
    end
  end

  AST_CNT_BELOW_RATIO: assert property (@(posedge clk_src) disable iff (!rst_n)
    cnt_q < ratio_q);  // R1
  AST_RATIO_FLOOR: assert property (@(posedge clk_src) disable iff (!rst_n)
    ratio_q >= MIN_RATIO);  // R2
  AST_WRAP_TO_ZERO: assert property (@(posedge clk_src) disable iff (!rst_n)
    at_end |=> (cnt_q == '0));  // R4
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk_src) disable iff (!rst_n)
    !at_end |=> ($stable(ratio_q) && $stable(en_q) && $stable(inv_q)));  // R7
endmodule

// File: rtl/cdiv_out_stage.sv
module cdiv_out_stage
  import cdiv_pkg::*;
(
  input  logic   clk_src,
  input  logic   rst_n,
  input  ratio_t cnt_nx,
  input  ratio_t high_nx,
  input  logic   en_nx,
  input  logic   inv_nx,
  output logic   clk_out
);
  logic phase_nx;
  assign phase_nx = (cnt_nx < high_nx);

  always_ff @(posedge clk_src) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= en_nx & (phase_nx ^ inv_nx);
  end
endmodule

// File: rtl/coded_clk_divider.sv
module coded_clk_divider
  import cdiv_pkg::*;
#(
  parameter bit TABLE_SEL = 1'b0
) (
  input  logic        clk_src,
  input  logic        rst_n,
  input  logic [3:0]  div_code,
  input  logic        inv_en,
  input  logic        out_en,
  output logic        clk_out
);
  ratio_t ratio_dec, high_dec;
  ratio_t cnt_nx, high_nx, cnt_q;
  logic   en_nx, inv_nx, en_q, inv_q, at_end;

  cdiv_ratio_decode #(.TABLE_SEL(TABLE_SEL)) u_decode (
    .code     (div_code),
    .ratio    (ratio_dec),
    .high_len (high_dec)
  );

  cdiv_period_ctr #(.TABLE_SEL(TABLE_SEL)) u_ctr (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .ratio_in (ratio_dec),
    .high_in  (high_dec),
    .en_in    (out_en),
    .inv_in   (inv_en),
    .cnt_nx   (cnt_nx),
    .high_nx  (high_nx),
    .en_nx    (en_nx),
    .inv_nx   (inv_nx),
    .cnt_q    (cnt_q),
    .en_q     (en_q),
    .inv_q    (inv_q),
    .at_end   (at_end)
  );

  cdiv_out_stage u_out (
    .clk_src (clk_src),
    .rst_n   (rst_n),
    .cnt_nx  (cnt_nx),
    .high_nx (high_nx),
    .en_nx   (en_nx),
    .inv_nx  (inv_nx),
    .clk_out (clk_out)
  );

  AST_OFF_HOLDS_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
    !en_q |-> !clk_out);  // R6
  AST_PERIOD_OPENS_HIGH: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cnt_q == '0 && en_q && !inv_q) |-> clk_out);  // R4
  AST_INVERT_OPENS_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
    (cnt_q == '0 && en_q && inv_q) |-> !clk_out);  // R5
  AST_NO_RUNT_RISE: assert property (@(posedge clk_src) disable iff (!rst_n)
    ($rose(clk_out) && !inv_q) |-> (cnt_q == '0));  // R7
  AST_END_IS_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
    (at_end && !inv_q) |-> !clk_out);  // R4
endmodule

// File: tb/coded_clk_divider_bench.sv
`timescale 1ns/1ps
module coded_clk_divider_bench;
  typedef struct {
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst0 = 1'b0, rst1 = 1'b0;
  logic [3:0] code0 = 4'd1, code1 = 4'd0;
  logic       inv0 = 1'b0, inv1 = 1'b0, en0 = 1'b1, en1 = 1'b1;
  logic       out0, out1;

  exp_t q0[$];
  exp_t q1[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  coded_clk_divider #(.TABLE_SEL(1'b0)) u_coded_clk_divider (
    .clk_src(clk), .rst_n(rst0), .div_code(code0),
    .inv_en(inv0), .out_en(en0), .clk_out(out0));

  coded_clk_divider #(.TABLE_SEL(1'b1)) u_coded_clk_divider_pci (
    .clk_src(clk), .rst_n(rst1), .div_code(code1),
    .inv_en(inv1), .out_en(en1), .clk_out(out1));

  // ratio restated from the requirements: base table times 2^k
  function automatic int bench_ratio(input int tbl, input logic [3:0] c);
    int b;
    int m;
    case (c[1:0])
      2'd0: b = (tbl == 1) ? 4 : 2;
      2'd1: b = 3;
      2'd2: b = 5;
      default: b = (tbl == 1) ? 9 : 7;
    endcase
    m = 1;
    for (int i = 0; i < int'(c[3:2]); i++) m = m * 2;
    return b * m;
  endfunction

  task automatic compare(input logic act, input logic expv, input string tag, input string who);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, who, act, expv, $time);
    end
  endtask

  task automatic set_in(input int d, input logic [3:0] c, input logic iv, input logic e);
    if (d == 0) begin code0 = c; inv0 = iv; en0 = e; end
    else        begin code1 = c; inv1 = iv; en1 = e; end
  endtask

  // driver: one output period, expected bits pushed to the scoreboard
  task automatic drive(input int d, input logic [3:0] c, input logic iv,
                       input logic e, input string tag);
    int   n;
    exp_t item;
    @(negedge clk);
    set_in(d, c, iv, e);
    n = bench_ratio(d, c);
    for (int k = 0; k < n; k++) begin
      item.val = e ? ((k < n / 2) ^ iv) : 1'b0;
      item.tag = tag;
      if (d == 0) q0.push_back(item);
      else        q1.push_back(item);
    end
    @(posedge clk);
    #1 set_in(d, ~c, ~iv, ~e);  // R7: mid-period changes must be ignored
    repeat (n - 1) @(posedge clk);
  endtask

  // monitor: pops one expected bit per source cycle after each edge
  always @(posedge clk) begin
    #1;
    if (q0.size() > 0) begin
      exp_t e0;
      e0 = q0.pop_front();
      compare(out0, e0.val, e0.tag, "cpu");
    end
    if (q1.size() > 0) begin
      exp_t e1;
      e1 = q1.pop_front();
      compare(out1, e1.val, e1.tag, "pci");
    end
  end

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog R1..: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    compare(out0, 1'b0, "R8 reset low", "cpu");
    compare(out1, 1'b0, "R8 reset low", "pci");
    @(posedge clk);
    #1 rst0 = 1'b1;
    // R8: first period uses the code held during reset
    drive(0, 4'b0001, 1'b0, 1'b1, "R8 first period /3");
    drive(0, 4'b0000, 1'b0, 1'b1, "R1 base /2");
    drive(0, 4'b0001, 1'b0, 1'b1, "R1 R4 base /3 odd duty");
    drive(0, 4'b0010, 1'b0, 1'b1, "R1 R4 base /5");
    drive(0, 4'b0011, 1'b0, 1'b1, "R1 base /7");
    drive(0, 4'b0101, 1'b0, 1'b1, "R2 x2 /6");
    drive(0, 4'b0111, 1'b0, 1'b1, "R2 x2 /14");
    drive(0, 4'b1011, 1'b0, 1'b1, "R2 x4 /28");
    drive(0, 4'b1111, 1'b0, 1'b1, "R2 x8 /56");
    drive(0, 4'b0010, 1'b1, 1'b1, "R5 invert /5");
    drive(0, 4'b0100, 1'b1, 1'b1, "R5 invert /4");
    drive(0, 4'b0001, 1'b0, 1'b0, "R6 disabled /3");
    drive(0, 4'b1010, 1'b1, 1'b0, "R6 disabled inverted /20");
    drive(0, 4'b0011, 1'b0, 1'b1, "R7 re-enable /7");
    repeat (2) @(posedge clk);
    #1 compare(out1, 1'b0, "R8 held in reset", "pci");
    @(posedge clk);
    #1 rst1 = 1'b1;
    drive(1, 4'b0000, 1'b0, 1'b1, "R3 base /4");
    drive(1, 4'b0001, 1'b0, 1'b1, "R3 base /3");
    drive(1, 4'b0010, 1'b0, 1'b1, "R3 base /5");
    drive(1, 4'b0011, 1'b0, 1'b1, "R3 R4 base /9");
    drive(1, 4'b1111, 1'b0, 1'b1, "R2 x8 /72");
    drive(1, 4'b0111, 1'b1, 1'b1, "R5 invert /18");
    drive(1, 4'b0001, 1'b0, 1'b0, "R6 disabled /3");
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule